// File: doc/BRIEF.md
# Processor Operating-Mode Control Register Sequencer

This block holds the four control registers that decide which operating mode a processor core runs in: the system control word (protection and paging enables), the translation root address, the extension control word (holding the physical-address-extension enable) and the extended feature word (holding the long-mode enable). Software updates them one at a time over a single write port that carries a register select and the privilege level of the writer. Any register can be read at any time through a combinational read port.

The block enforces the order in which the core must step from real mode to protected mode and into the 64-bit long mode, and back out again. It accepts or refuses each write against that order. It derives the long-mode-active flag itself from the paging, extension and long-mode enables, and software cannot write that flag. A refused write leaves every register as it was. It raises a one-cycle fault pulse if the write broke the ordering rules, or a one-cycle denial pulse if the writer was not at the most privileged level. A 2-bit mode output and an interrupt-enable gate go to the rest of the core. When long mode is active, the code-segment long-attribute input selects between the 64-bit and the compatibility sub-modes.

Top module: `msq_mode_ctl`

## Requirements
- R1: After reset, all four registers read zero, `mode_o` is 0 (real), `wr_fault_o` and `wr_denied_o` are 0 and `intr_gate_o` is 1.
- R2: `rd_data_o` follows `rd_sel_i` combinationally. The select encoding is 0 = system control word, 1 = translation root, 2 = extension control word and 3 = extended feature word. The select encoding on `wr_sel_i` is the same.
- R3: The system control word keeps write bits 31:0 and reads zero above bit 31. Bit 0 is the protection enable and bit 31 is the paging enable. The translation root and the extension control word keep all 64 written bits. Bit 5 of the extension control word is the address-extension enable.
- R4: The extended feature word stores only write bits 0 (system-call enable), 8 (long-mode enable) and 11 (no-execute enable). Every other bit reads zero except bit 10.
- R5: Bit 10 of the extended feature word reads the long-mode-active flag. Writes to bit 10 are ignored.
- R6: The long-mode-active flag becomes 1 on an accepted write to the system control word that sets bit 31 while it was 0, provided long-mode enable and address-extension enable are both 1. It becomes 0 on any accepted write to the system control word with bit 31 clear.
- R7: The following writes are refused with an ordering fault:
  - a system-control write that sets bit 31 from 0 while long-mode enable is 1 and address-extension enable is 0;
  - a system-control write with bit 31 set and bit 0 clear.
- R8: The following writes are also refused with an ordering fault:
  - a feature write that changes long-mode enable while paging is on;
  - an extension-control write that clears bit 5 while long mode is active.
- R9: A refused write changes no register. An ordering fault sets `wr_fault_o` to 1 for exactly the cycle after the write.
- R10: A write with `wr_priv_i` other than 0 is refused regardless of the rules. It sets `wr_denied_o` to 1 for the cycle after the write and changes no register.
- R11: `mode_o` is 0 when protection is off, 1 when protection is on and long mode is not active, 2 when long mode is active with `cs_long_i` = 1, and 3 when long mode is active with `cs_long_i` = 0.
- R12: `intr_gate_o` is 0 exactly while long-mode enable is 1 and long mode is not active. This is the window in which the transition is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 2 | Register select for the write |
| wr_data_i | input | 64 | Write data |
| wr_priv_i | input | 2 | Privilege level of the writer (0 = most privileged) |
| rd_sel_i | input | 2 | Register select for the read |
| rd_data_o | output | 64 | Combinational read data |
| cs_long_i | input | 1 | Long attribute of the current code segment |
| mode_o | output | 2 | Current operating mode |
| wr_fault_o | output | 1 | Pulse: the previous write broke the ordering rules |
| wr_denied_o | output | 1 | Pulse: the previous write came from a non-zero privilege level |
| intr_gate_o | output | 1 | Interrupts may be taken |

## Verification
A wrong long-mode-active state shows at the ports without delay. It appears at once in `mode_o`, in bit 10 of the feature word and in `intr_gate_o`. A wrong copy of a stored enable shows the first time a later write depends on it: a fault appears or fails to appear one cycle after that write. The bench reads back all four registers on every cycle and compares every output against a behavioural model. Any divergence is therefore reported no later than the cycle after the write that caused it.

// File: rtl/msq_pkg.sv
package msq_pkg;
    localparam int REG_W    = 64;
    localparam int SYS_W    = 32;
    localparam int SEL_W    = 2;
    localparam int PRIV_W   = 2;
    localparam int MODE_W   = 2;

    localparam int SYS_PROT_BIT   = 0;
    localparam int SYS_PAGE_BIT   = 31;
    localparam int EXT_ADDR_BIT   = 5;
    localparam int FEAT_SCALL_BIT = 0;
    localparam int FEAT_LONG_BIT  = 8;
    localparam int FEAT_ACT_BIT   = 10;
    localparam int FEAT_NOEX_BIT  = 11;

    typedef enum logic [SEL_W-1:0] {
        SEL_SYS  = 2'd0,
        SEL_ROOT = 2'd1,
        SEL_EXT  = 2'd2,
        SEL_FEAT = 2'd3
    } sel_e;

    typedef enum logic [MODE_W-1:0] {
        MODE_REAL   = 2'd0,
        MODE_PROT   = 2'd1,
        MODE_LONG64 = 2'd2,
        MODE_COMPAT = 2'd3
    } mode_e;

    typedef struct packed {
        logic [SYS_W-1:0] sys;
        logic [REG_W-1:0] root;
        logic [REG_W-1:0] ext;
        logic             scall;
        logic             lme;
        logic             noex;
        logic             lma;
        logic             fault;
        logic             denied;
    } state_t;
endpackage

// File: rtl/msq_rule_check.sv
module msq_rule_check
    import msq_pkg::*;
(
    input  sel_e wr_sel_i,
    input  logic new_pg_i,
    input  logic new_pe_i,
    input  logic new_pae_i,
    input  logic new_lme_i,
    input  logic cur_pg_i,
    input  logic cur_lme_i,
    input  logic cur_pae_i,
    input  logic cur_lma_i,
    output logic fault_o,
    output logic lma_on_o,
    output logic lma_off_o
);
    logic pg_rising;
    logic pg_without_pe;
    logic pg_missing_pae;

    always_comb begin
        pg_rising      = new_pg_i & ~cur_pg_i;
        pg_without_pe  = new_pg_i & ~new_pe_i;
        pg_missing_pae = pg_rising & cur_lme_i & ~cur_pae_i;
        lma_on_o       = pg_rising & cur_lme_i & cur_pae_i;
        lma_off_o      = ~new_pg_i;
        unique case (wr_sel_i)
            SEL_SYS:  fault_o = pg_without_pe | pg_missing_pae;
            SEL_EXT:  fault_o = cur_lma_i & ~new_pae_i;
            SEL_FEAT: fault_o = cur_pg_i & (new_lme_i != cur_lme_i);
            default:  fault_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/msq_mode_dec.sv
module msq_mode_dec
    import msq_pkg::*;
(
    input  logic  pe_i,
    input  logic  lme_i,
    input  logic  lma_i,
    input  logic  cs_long_i,
    output mode_e mode_o,
    output logic  intr_gate_o
);
    always_comb begin
        if (!pe_i)          mode_o = MODE_REAL;
        else if (!lma_i)    mode_o = MODE_PROT;
        else if (cs_long_i) mode_o = MODE_LONG64;
        else                mode_o = MODE_COMPAT;
        intr_gate_o = ~(lme_i & ~lma_i);
    end
endmodule

// File: rtl/msq_read_mux.sv
module msq_read_mux
    import msq_pkg::*;
(
    input  state_t           state_i,
    input  sel_e             rd_sel_i,
    output logic [REG_W-1:0] rd_data_o
);
    logic [REG_W-1:0] feat_view;
    logic [REG_W-1:0] sys_view;

    always_comb begin
        feat_view                 = '0;
        feat_view[FEAT_SCALL_BIT] = state_i.scall;
        feat_view[FEAT_LONG_BIT]  = state_i.lme;
        feat_view[FEAT_ACT_BIT]   = state_i.lma;
        feat_view[FEAT_NOEX_BIT]  = state_i.noex;
        sys_view                  = '0;
        sys_view[SYS_W-1:0]       = state_i.sys;
        unique case (rd_sel_i)
            SEL_SYS:  rd_data_o = sys_view;
            SEL_ROOT: rd_data_o = state_i.root;
            SEL_EXT:  rd_data_o = state_i.ext;
            default:  rd_data_o = feat_view;
        endcase
    end
endmodule

// File: rtl/msq_mode_ctl.sv
module msq_mode_ctl
    import msq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [SEL_W-1:0]  wr_sel_i,
    input  logic [REG_W-1:0]  wr_data_i,
    input  logic [PRIV_W-1:0] wr_priv_i,
    input  logic [SEL_W-1:0]  rd_sel_i,
    output logic [REG_W-1:0]  rd_data_o,
    input  logic              cs_long_i,
    output logic [MODE_W-1:0] mode_o,
    output logic              wr_fault_o,
    output logic              wr_denied_o,
    output logic              intr_gate_o
);
    state_t s_d, s_q;
    logic   chk_fault, chk_lma_on, chk_lma_off;
    mode_e  mode_w;
    sel_e   wr_sel_w, rd_sel_w;

    assign wr_sel_w = sel_e'(wr_sel_i);
    assign rd_sel_w = sel_e'(rd_sel_i);

    msq_rule_check u_rules (
        .wr_sel_i  (wr_sel_w),
        .new_pg_i  (wr_data_i[SYS_PAGE_BIT]),
        .new_pe_i  (wr_data_i[SYS_PROT_BIT]),
        .new_pae_i (wr_data_i[EXT_ADDR_BIT]),
        .new_lme_i (wr_data_i[FEAT_LONG_BIT]),
        .cur_pg_i  (s_q.sys[SYS_PAGE_BIT]),
        .cur_lme_i (s_q.lme),
        .cur_pae_i (s_q.ext[EXT_ADDR_BIT]),
        .cur_lma_i (s_q.lma),
        .fault_o   (chk_fault),
        .lma_on_o  (chk_lma_on),
        .lma_off_o (chk_lma_off)
    );

    always_comb begin
        s_d        = s_q;
        s_d.fault  = 1'b0;
        s_d.denied = 1'b0;
        if (wr_en_i) begin
            if (wr_priv_i != '0) begin
                s_d.denied = 1'b1;
            end else if (chk_fault) begin
                s_d.fault = 1'b1;
            end else begin
                unique case (wr_sel_w)
                    SEL_SYS: begin
                        s_d.sys = wr_data_i[SYS_W-1:0];
                        if (chk_lma_on)       s_d.lma = 1'b1;
                        else if (chk_lma_off) s_d.lma = 1'b0;
                    end
                    SEL_ROOT: s_d.root = wr_data_i;
                    SEL_EXT:  s_d.ext  = wr_data_i;
                    default: begin
                        s_d.scall = wr_data_i[FEAT_SCALL_BIT];
                        s_d.lme   = wr_data_i[FEAT_LONG_BIT];
                        s_d.noex  = wr_data_i[FEAT_NOEX_BIT];
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    msq_mode_dec u_mode (
        .pe_i        (s_q.sys[SYS_PROT_BIT]),
        .lme_i       (s_q.lme),
        .lma_i       (s_q.lma),
        .cs_long_i   (cs_long_i),
        .mode_o      (mode_w),
        .intr_gate_o (intr_gate_o)
    );

    msq_read_mux u_read (
        .state_i   (s_q),
        .rd_sel_i  (rd_sel_w),
        .rd_data_o (rd_data_o)
    );

    assign mode_o      = mode_w;
    assign wr_fault_o  = s_q.fault;
    assign wr_denied_o = s_q.denied;
endmodule

// File: rtl/msq_mode_ctl_chk.sv
module msq_mode_ctl_chk
    import msq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en_i,
    input logic [PRIV_W-1:0] wr_priv_i,
    input logic [MODE_W-1:0] mode_o,
    input logic              wr_fault_o,
    input logic              wr_denied_o,
    input logic              intr_gate_o,
    input logic              pg,
    input logic              pe,
    input logic              pae,
    input logic              lme,
    input logic              lma,
    input logic [REG_W-1:0]  root,
    input logic [REG_W-1:0]  ext
);
    // R6: the active flag only stands on paging with both enables
    a_r6_active_needs_enables: assert property (@(posedge clk) disable iff (!rst_n)
        lma |-> (pg && pae && lme));

    // R11: protection off means real mode
    a_r11_real_without_prot: assert property (@(posedge clk) disable iff (!rst_n)
        !pe |-> (mode_o == 2'd0));

    // R10: a denied write leaves the state untouched
    a_r10_denied_holds_state: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_priv_i != '0) |=> ($stable(root) && $stable(ext) && $stable(pg)
                                          && $stable(pe) && $stable(lme)));

    // R8: long-mode enable is frozen while paging stays on
    a_r8_lme_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        pg |=> (!pg || $stable(lme)));

    // R7: paging is never held without protection
    a_r7_paging_needs_prot: assert property (@(posedge clk) disable iff (!rst_n)
        pg |-> pe);

    // R9: a cycle reports at most one kind of refusal
    a_r9_one_refusal: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_fault_o, wr_denied_o}));

    // R12: interrupts are open once long mode is active
    a_r12_gate_open_in_long: assert property (@(posedge clk) disable iff (!rst_n)
        lma |-> intr_gate_o);
endmodule

bind msq_mode_ctl msq_mode_ctl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_i     (wr_en_i),
    .wr_priv_i   (wr_priv_i),
    .mode_o      (mode_o),
    .wr_fault_o  (wr_fault_o),
    .wr_denied_o (wr_denied_o),
    .intr_gate_o (intr_gate_o),
    .pg          (s_q.sys[31]),
    .pe          (s_q.sys[0]),
    .pae         (s_q.ext[5]),
    .lme         (s_q.lme),
    .lma         (s_q.lma),
    .root        (s_q.root),
    .ext         (s_q.ext)
);

// File: tb/tb_msq_mode_ctl.sv
module tb_msq_mode_ctl;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 200000;
    localparam int RAND_CYCLES = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [63:0] wr_data = '0;
    logic [1:0]  wr_priv = '0;
    logic [1:0]  rd_sel = '0;
    logic [63:0] rd_data;
    logic        cs_long = 1'b0;
    logic [1:0]  mode;
    logic        wr_fault, wr_denied, intr_gate;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    // reference state
    logic [63:0] m_sys, m_root, m_ext;
    logic        m_scall, m_lme, m_noex, m_lma, m_flt, m_den;

    msq_mode_ctl dut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
        .wr_data_i(wr_data), .wr_priv_i(wr_priv), .rd_sel_i(rd_sel),
        .rd_data_o(rd_data), .cs_long_i(cs_long), .mode_o(mode),
        .wr_fault_o(wr_fault), .wr_denied_o(wr_denied), .intr_gate_o(intr_gate)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sys = 0; m_root = 0; m_ext = 0;
            m_scall = 0; m_lme = 0; m_noex = 0; m_lma = 0; m_flt = 0; m_den = 0;
        end else begin
            m_flt = 0; m_den = 0;
            if (wr_en) begin
                if (wr_priv != 0) m_den = 1;
                else begin
                    case (wr_sel)
                        2'd0: begin
                            if ((wr_data[31] && !wr_data[0]) ||
                                (wr_data[31] && !m_sys[31] && m_lme && !m_ext[5])) m_flt = 1;
                            else begin
                                if (wr_data[31] && !m_sys[31] && m_lme && m_ext[5]) m_lma = 1;
                                if (!wr_data[31]) m_lma = 0;
                                m_sys = {32'h0, wr_data[31:0]};
                            end
                        end
                        2'd1: m_root = wr_data;
                        2'd2: if (m_lma && !wr_data[5]) m_flt = 1; else m_ext = wr_data;
                        default: begin
                            if (m_sys[31] && wr_data[8] != m_lme) m_flt = 1;
                            else begin
                                m_scall = wr_data[0]; m_lme = wr_data[8]; m_noex = wr_data[11];
                            end
                        end
                    endcase
                end
            end
        end
    end

    function automatic logic [63:0] exp_read(input int s);
        logic [63:0] f;
        f = 0;
        f[0] = m_scall; f[8] = m_lme; f[10] = m_lma; f[11] = m_noex;
        case (s)
            0: return m_sys;
            1: return m_root;
            2: return m_ext;
            default: return f;
        endcase
    endfunction

    function automatic logic [1:0] exp_mode();
        if (!m_sys[0]) return 2'd0;
        if (!m_lma) return 2'd1;
        return cs_long ? 2'd2 : 2'd3;
    endfunction

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare everything; called just after a falling edge
    task automatic compare_all();
        for (int s = 0; s < 4; s++) begin
            rd_sel = s[1:0];
            #1;
            case (s)
                0: chk(rd_data, exp_read(s), "R3 system word read (R2)");
                1: chk(rd_data, exp_read(s), "R3 root read (R2)");
                2: chk(rd_data, exp_read(s), "R3 extension word read (R2)");
                default: chk(rd_data, exp_read(s), "R4/R5 feature word read");
            endcase
        end
        chk({62'h0, mode}, {62'h0, exp_mode()}, "R11 mode");
        chk({63'h0, wr_fault}, {63'h0, m_flt}, "R9 fault pulse");
        chk({63'h0, wr_denied}, {63'h0, m_den}, "R10 denied pulse");
        chk({63'h0, intr_gate}, {63'h0, !(m_lme && !m_lma)}, "R12 interrupt gate");
    endtask

    task automatic cyc(input logic en, input logic [1:0] sel, input logic [63:0] d,
                       input logic [1:0] priv, input logic csl);
        @(negedge clk);
        compare_all();
        wr_en = en; wr_sel = sel; wr_data = d; wr_priv = priv; cs_long = csl;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [63:0] d);
        cyc(1'b1, sel, d, 2'd0, cs_long);
    endtask

    task automatic idle();
        cyc(1'b0, 2'd0, 64'h0, 2'd0, cs_long);
    endtask

    initial begin
        #(CLK_PERIOD * MAX_CYCLES);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual running expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();                                   // R1 reset state compared here
        // R10: privilege 3 write refused
        cyc(1'b1, 2'd0, 64'h1, 2'd3, 1'b0);
        idle();
        // enter protected mode
        wr(2'd0, 64'hFFFF_FFFF_0000_0001);        // R3 upper half dropped
        // R4/R5: feature write with bit 10 and stray bits set
        wr(2'd3, 64'hFFFF_0000_0000_0F01);
        idle();                                   // R12 gate low now
        // R7: paging with long enable but no address extension
        wr(2'd0, 64'h8000_0001);
        idle();
        wr(2'd2, 64'hA5A5_0000_0000_0020);
        wr(2'd1, 64'h1234_5678_9ABC_D000);
        // R6: activate long mode
        wr(2'd0, 64'h8000_0001);
        cyc(1'b0, 2'd0, 64'h0, 2'd0, 1'b1);       // R11 long 64
        cyc(1'b0, 2'd0, 64'h0, 2'd0, 1'b0);       // R11 compat
        // R8: change long enable under paging, clear extension in long mode
        wr(2'd3, 64'h0);
        wr(2'd2, 64'h0);
        // R7: paging without protection
        wr(2'd0, 64'h8000_0000);
        // R10 during long mode
        cyc(1'b1, 2'd0, 64'h0, 2'd1, 1'b1);
        // leave: clear paging, then protection
        wr(2'd0, 64'h1);
        wr(2'd0, 64'h0);
        // legacy paging path without long enable
        wr(2'd3, 64'h800);
        wr(2'd0, 64'h8000_0001);
        wr(2'd3, 64'h100);                        // R8 refused
        wr(2'd0, 64'h0);
        idle();
        // mixed stimulus
        r = 32'h1ACE_B00C;
        for (int i = 0; i < RAND_CYCLES; i++) begin
            logic [63:0] d;
            r ^= r << 13; r ^= r >> 17; r ^= r << 5;
            d = {r, r ^ 32'h5A5A_1234};
            if (r[9]) d[31] = r[10];
            d[0] = r[11] | r[12];
            d[5] = r[13] | r[14];
            d[8] = r[15] & r[16];
            cyc(r[2] | r[3], r[5:4], d, (r[8:6] == 0) ? r[18:17] : 2'd0, r[19]);
            if (r[24:20] == 0) begin
                @(negedge clk); compare_all();
                rst_n = 1'b0; wr_en = 1'b0;
                @(negedge clk); compare_all();
                rst_n = 1'b1;
            end
        end
        idle();
        idle();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule